// File: doc/BRIEF.md
# Signature-Aware Re-Reference Replacement Controller for One Cache Set

This block holds the replacement state of a single set in a set-associative last-level cache. Each way carries a 2-bit re-reference value, a valid bit, a reuse bit, the 14-bit signature that caused the line's install and a flag that marks a line brought in by a prefetch. The surrounding cache does the tag compare and tells the block whether the access hit and, on a hit, which way matched.

On a miss the block picks the way to fill. Empty ways come first. When the set is full it picks the victim among the lines predicted to be re-referenced furthest away. The new line gets a starting re-reference value chosen from the confidence of an external signature predictor, and writebacks are always placed at the distant end. When a valid line is displaced, its signature, prefetch flag and reuse bit go out on a one-cycle training output so that the predictor can learn.

On a hit a demand access promotes the line to the nearest state. The first demand touch of a prefetched line only clears its prefetch mark.

Top module: `rrip_set_ctrl`

## Requirements
- R1: After reset every way is invalid and shows re-reference value 3 on `rrpvView`, and `fillValid` and `trainValid` are 0.
- R2: A miss while any way is invalid fills the lowest-numbered invalid way. It does not age any line and does not assert `trainValid`.
- R3: A miss on a full set chooses the lowest-numbered way that holds the largest re-reference value. Every other way's value rises by (3 minus that largest value), which gives the same result as incrementing all ways until one reaches 3. The whole miss completes in one cycle.
- R4: A non-writeback fill is installed at value 0 when `predCtr` is 7, at value 2 when `predCtr` is from 1 to 6, and at value 3 when `predCtr` is 0.
- R5: A fill with `reqWb`=1 is installed at value 3, whatever `predCtr` is.
- R6: A demand hit (`reqPf`=0) on a line whose prefetch flag is clear sets that line's value to 0 and sets its reuse bit.
- R7: A demand hit on a line installed by a prefetch (`reqPf`=1 at fill) clears its prefetch flag, sets its reuse bit and leaves its value unchanged. A later demand hit then promotes it to 0.
- R8: A hit with `reqPf`=1 changes no value, flag or reuse bit.
- R9: When a valid line is displaced, `trainValid` is 1 and `trainSig`, `trainPf` and `trainReuse` carry that line's stored signature, its current prefetch flag and its reuse bit. The reuse bit is cleared at install and set by any demand hit after it.
- R10: `fillValid`/`fillWay` and the training outputs are registered. They are valid in the cycle after the request and last one cycle. `rrpvView` packs way w's value in bits [2w+1:2w].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request this cycle |
| reqHit | input | 1 | 1 when the access hit in the set |
| reqWay | input | WAY_W | Way that hit (used on hits only) |
| reqSig | input | SIG_W | Signature of the access, stored on fill |
| reqPf | input | 1 | Access is a prefetch |
| reqWb | input | 1 | Access is a writeback fill |
| predCtr | input | CTR_W | Predictor counter for the access signature |
| fillValid | output | 1 | A fill happened in the previous cycle |
| fillWay | output | WAY_W | Way that was filled |
| trainValid | output | 1 | A valid line was displaced |
| trainSig | output | SIG_W | Signature of the displaced line |
| trainPf | output | 1 | Prefetch flag of the displaced line |
| trainReuse | output | 1 | Reuse bit of the displaced line |
| rrpvView | output | 2*NUM_WAYS | Current re-reference value of every way |

## Verification
The bench targets victim ties and aging amounts on a full set. A design that searched from the wrong end or aged by a fixed step would show a wrong `fillWay` or wrong values on `rrpvView`. It drives the predictor counter at 0, at 7 and in between, and drives writebacks with a saturated counter, so that an off-by-one in the confidence bands or a missing writeback override shows up as a wrong install value. Prefetched lines are touched twice by demand accesses and also hit by prefetches, which catches a design that promotes on the first touch or lets prefetch hits change state. The training outputs are compared on every eviction, so a stale reuse bit or a mixed-up signature fails.

// File: rtl/rrip_set_pkg.sv
package rrip_set_pkg;
  localparam int RRPV_W = 2;
  typedef logic [RRPV_W-1:0] rrpv_t;

  localparam rrpv_t RRPV_NEAR    = 2'd0;
  localparam rrpv_t RRPV_FAR     = 2'd2;
  localparam rrpv_t RRPV_DISTANT = 2'd3;

  // Strobes from control to datapath; at most one action bit is set per cycle.
  typedef struct packed {
    logic  hitPromote;
    logic  pfTouch;
    logic  fillEmpty;
    logic  evict;
    rrpv_t insState;
  } ctrl_strobe_t;
endpackage

// File: rtl/rrip_victim_find.sv
module rrip_victim_find
  import rrip_set_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]        validVec,
  input  logic [2*NUM_WAYS-1:0]      rrpvFlat,
  output logic                       hasInvalid,
  output logic [WAY_W-1:0]           firstInvalid,
  output logic [WAY_W-1:0]           victimWay,
  output rrpv_t                      ageDelta
);
  rrpv_t maxVal;

  always_comb begin
    hasInvalid   = 1'b0;
    firstInvalid = '0;
    maxVal       = RRPV_NEAR;
    victimWay    = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        hasInvalid   = 1'b1;
        firstInvalid = WAY_W'(i);
      end
    end
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (rrpvFlat[2*i +: 2] > maxVal) maxVal = rrpvFlat[2*i +: 2];
    end
    // Descending scan so the lowest-numbered way with the largest value wins.
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (rrpvFlat[2*i +: 2] == maxVal) victimWay = WAY_W'(i);
    end
    ageDelta = RRPV_DISTANT - maxVal;
  end
endmodule

// File: rtl/rrip_set_ctl.sv
module rrip_set_ctl
  import rrip_set_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int CTR_W = 3,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}}
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqHit,
  input  logic [WAY_W-1:0]    reqWay,
  input  logic                reqPf,
  input  logic                reqWb,
  input  logic [CTR_W-1:0]    predCtr,
  input  logic [NUM_WAYS-1:0] validVec,
  input  logic [NUM_WAYS-1:0] pfVec,
  input  logic                hasInvalid,
  input  logic [WAY_W-1:0]    firstInvalid,
  input  logic [WAY_W-1:0]    victimWay,
  output ctrl_strobe_t        strb,
  output logic [WAY_W-1:0]    tgtWay
);
  logic demandHit;
  logic missReq;

  assign demandHit = reqValid && reqHit && !reqPf && validVec[reqWay];
  assign missReq   = reqValid && !reqHit;

  always_comb begin
    strb.hitPromote = demandHit && !pfVec[reqWay];
    strb.pfTouch    = demandHit && pfVec[reqWay];
    strb.fillEmpty  = missReq && hasInvalid;
    strb.evict      = missReq && !hasInvalid;
    if (reqWb)                 strb.insState = RRPV_DISTANT;
    else if (predCtr == CTR_MAX) strb.insState = RRPV_NEAR;
    else if (predCtr == '0)    strb.insState = RRPV_DISTANT;
    else                       strb.insState = RRPV_FAR;

    if (strb.fillEmpty)      tgtWay = firstInvalid;
    else if (strb.evict)     tgtWay = victimWay;
    else                     tgtWay = reqWay;
  end

  // R10: one action per cycle
  p_one_action_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.hitPromote, strb.pfTouch, strb.fillEmpty, strb.evict}));
endmodule

// File: rtl/rrip_set_dp.sv
module rrip_set_dp
  import rrip_set_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int SIG_W = 14,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrl_strobe_t           strb,
  input  logic [WAY_W-1:0]       tgtWay,
  input  logic [SIG_W-1:0]       reqSig,
  input  logic                   reqPf,
  output logic [NUM_WAYS-1:0]    validVec,
  output logic [NUM_WAYS-1:0]    pfVec,
  output logic                   hasInvalid,
  output logic [WAY_W-1:0]       firstInvalid,
  output logic [WAY_W-1:0]       victimWay,
  output logic                   fillValid,
  output logic [WAY_W-1:0]       fillWay,
  output logic                   trainValid,
  output logic [SIG_W-1:0]       trainSig,
  output logic                   trainPf,
  output logic                   trainReuse,
  output logic [2*NUM_WAYS-1:0]  rrpvView
);
  rrpv_t            rrpvQ  [NUM_WAYS];
  logic [SIG_W-1:0] sigQ   [NUM_WAYS];
  logic [NUM_WAYS-1:0] validQ, pfQ, reuseQ;
  rrpv_t            ageDelta;

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_view
    assign rrpvView[2*g +: 2] = rrpvQ[g];
  end

  assign validVec = validQ;
  assign pfVec    = pfQ;

  rrip_victim_find #(.NUM_WAYS(NUM_WAYS)) u_find (
    .validVec     (validQ),
    .rrpvFlat     (rrpvView),
    .hasInvalid   (hasInvalid),
    .firstInvalid (firstInvalid),
    .victimWay    (victimWay),
    .ageDelta     (ageDelta)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ     <= '0;
      pfQ        <= '0;
      reuseQ     <= '0;
      fillValid  <= 1'b0;
      fillWay    <= '0;
      trainValid <= 1'b0;
      trainSig   <= '0;
      trainPf    <= 1'b0;
      trainReuse <= 1'b0;
      for (int i = 0; i < NUM_WAYS; i++) begin
        rrpvQ[i] <= RRPV_DISTANT;
        sigQ[i]  <= '0;
      end
    end else begin
      fillValid  <= 1'b0;
      trainValid <= 1'b0;
      if (strb.hitPromote) begin
        rrpvQ[tgtWay]  <= RRPV_NEAR;
        reuseQ[tgtWay] <= 1'b1;
      end
      if (strb.pfTouch) begin
        pfQ[tgtWay]    <= 1'b0;
        reuseQ[tgtWay] <= 1'b1;
      end
      if (strb.evict) begin
        for (int i = 0; i < NUM_WAYS; i++) begin
          if (i != int'(tgtWay)) rrpvQ[i] <= rrpv_t'(rrpvQ[i] + ageDelta);
        end
        trainValid <= 1'b1;
        trainSig   <= sigQ[tgtWay];
        trainPf    <= pfQ[tgtWay];
        trainReuse <= reuseQ[tgtWay];
      end
      if (strb.fillEmpty || strb.evict) begin
        validQ[tgtWay] <= 1'b1;
        rrpvQ[tgtWay]  <= strb.insState;
        sigQ[tgtWay]   <= reqSig;
        pfQ[tgtWay]    <= reqPf;
        reuseQ[tgtWay] <= 1'b0;
        fillValid      <= 1'b1;
        fillWay        <= tgtWay;
      end
    end
  end

  // R2: eviction only when the set is full
  p_evict_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.evict |-> (&validQ));

  // R7: first demand touch of a prefetched line keeps its value
  p_pf_touch_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.pfTouch |=> (rrpvQ[$past(tgtWay)] == $past(rrpvQ[tgtWay])));

  // R9: training output only accompanies a fill
  p_train_with_fill_r9: assert property (@(posedge clk) disable iff (!rstN)
    trainValid |-> fillValid);
endmodule

// File: rtl/rrip_set_ctrl.sv
module rrip_set_ctrl
  import rrip_set_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int SIG_W = 14,
  parameter int CTR_W = 3,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqHit,
  input  logic [WAY_W-1:0]      reqWay,
  input  logic [SIG_W-1:0]      reqSig,
  input  logic                  reqPf,
  input  logic                  reqWb,
  input  logic [CTR_W-1:0]      predCtr,
  output logic                  fillValid,
  output logic [WAY_W-1:0]      fillWay,
  output logic                  trainValid,
  output logic [SIG_W-1:0]      trainSig,
  output logic                  trainPf,
  output logic                  trainReuse,
  output logic [2*NUM_WAYS-1:0] rrpvView
);
  ctrl_strobe_t        strb;
  logic [WAY_W-1:0]    tgtWay;
  logic [NUM_WAYS-1:0] validVec, pfVec;
  logic                hasInvalid;
  logic [WAY_W-1:0]    firstInvalid, victimWay;

  rrip_set_ctl #(.NUM_WAYS(NUM_WAYS), .CTR_W(CTR_W)) u_ctl (
    .clk, .rstN, .reqValid, .reqHit, .reqWay, .reqPf, .reqWb, .predCtr,
    .validVec, .pfVec, .hasInvalid, .firstInvalid, .victimWay,
    .strb, .tgtWay
  );

  rrip_set_dp #(.NUM_WAYS(NUM_WAYS), .SIG_W(SIG_W)) u_dp (
    .clk, .rstN, .strb, .tgtWay, .reqSig, .reqPf,
    .validVec, .pfVec, .hasInvalid, .firstInvalid, .victimWay,
    .fillValid, .fillWay, .trainValid, .trainSig, .trainPf, .trainReuse,
    .rrpvView
  );

  // R5: writeback fill lands at distant
  p_wb_distant_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqHit && reqWb) |=>
      (fillValid && rrpvView[2*int'(fillWay) +: 2] == 2'd3));

  // R4: saturated predictor installs at near
  p_sat_near_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqHit && !reqWb && predCtr == {CTR_W{1'b1}}) |=>
      (fillValid && rrpvView[2*int'(fillWay) +: 2] == 2'd0));
endmodule

// File: tb/rrip_set_ctrl_bench.sv
module rrip_set_ctrl_bench;
  localparam int NW = 8;
  localparam int SW = 14;
  localparam int WW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqHit = 0, reqPf = 0, reqWb = 0;
  logic [WW-1:0] reqWay = '0;
  logic [SW-1:0] reqSig = '0;
  logic [2:0] predCtr = '0;
  logic fillValid, trainValid, trainPf, trainReuse;
  logic [WW-1:0] fillWay;
  logic [SW-1:0] trainSig;
  logic [2*NW-1:0] rrpvView;

  int nTests = 0, nFail = 0;

  // model state
  int mRrpv [NW];
  bit mValid[NW], mPf[NW], mReuse[NW];
  int mSig [NW];

  always #10 clk = ~clk;

  rrip_set_ctrl u_rrip_set_ctrl (
    .clk, .rstN, .reqValid, .reqHit, .reqWay, .reqSig, .reqPf, .reqWb,
    .predCtr, .fillValid, .fillWay, .trainValid, .trainSig, .trainPf,
    .trainReuse, .rrpvView
  );

  task automatic check(string tag, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int insValue(int ctr, bit wb);
    if (wb) return 3;
    if (ctr == 7) return 0;
    if (ctr == 0) return 3;
    return 2;
  endfunction

  task automatic checkView(string tag);
    for (int w = 0; w < NW; w++) check(tag, int'(rrpvView[2*w +: 2]), mRrpv[w]);
  endtask

  // Drive one request at a negedge; compare one clock later at the next negedge.
  task automatic doReq(bit hit, int way, int sig, bit pf, bit wb, int ctr, string tag);
    bit expFill = 0, expTrain = 0;
    int expWay = 0, eSig = 0, eMax = 0;
    bit ePf = 0, eReuse = 0;
    reqValid = 1; reqHit = hit; reqWay = WW'(way); reqSig = SW'(sig);
    reqPf = pf; reqWb = wb; predCtr = 3'(ctr);
    if (hit) begin
      if (!pf && mValid[way]) begin
        if (mPf[way]) begin mPf[way] = 0; mReuse[way] = 1; end
        else begin mRrpv[way] = 0; mReuse[way] = 1; end
      end
    end else begin
      expFill = 1;
      expWay = -1;
      for (int w = NW - 1; w >= 0; w--) if (!mValid[w]) expWay = w;
      if (expWay < 0) begin
        for (int w = 0; w < NW; w++) if (mRrpv[w] > eMax) eMax = mRrpv[w];
        for (int w = NW - 1; w >= 0; w--) if (mRrpv[w] == eMax) expWay = w;
        expTrain = 1; eSig = mSig[expWay]; ePf = mPf[expWay]; eReuse = mReuse[expWay];
        for (int w = 0; w < NW; w++) if (w != expWay) mRrpv[w] += 3 - eMax;
      end
      mValid[expWay] = 1; mRrpv[expWay] = insValue(ctr, wb);
      mSig[expWay] = sig; mPf[expWay] = pf; mReuse[expWay] = 0;
    end
    @(negedge clk);
    reqValid = 0;
    check({tag, " R10 fillValid"}, int'(fillValid), int'(expFill));
    check({tag, " R9 trainValid"}, int'(trainValid), int'(expTrain));
    if (expFill) check({tag, " R2/R3 fillWay"}, int'(fillWay), expWay);
    if (expTrain) begin
      check({tag, " R9 trainSig"}, int'(trainSig), eSig);
      check({tag, " R9 trainPf"}, int'(trainPf), int'(ePf));
      check({tag, " R9 trainReuse"}, int'(trainReuse), int'(eReuse));
    end
    checkView({tag, " view"});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : main
    int seedDummy;
    seedDummy = $urandom(32'h5eed);
    for (int w = 0; w < NW; w++) begin
      mRrpv[w] = 3; mValid[w] = 0; mPf[w] = 0; mReuse[w] = 0; mSig[w] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    check("R1 fillValid", int'(fillValid), 0);
    check("R1 trainValid", int'(trainValid), 0);
    checkView("R1");
    // R2/R4/R5: fill empty ways with various confidence levels
    doReq(0, 0, 16'h0101, 0, 0, 7, "R4 ctr7");
    doReq(0, 0, 16'h0202, 0, 0, 4, "R4 ctr4");
    doReq(0, 0, 16'h0303, 0, 0, 0, "R4 ctr0");
    doReq(0, 0, 16'h0404, 0, 1, 7, "R5 wb");
    doReq(0, 0, 16'h0505, 1, 0, 1, "R7 pf fill");
    doReq(0, 0, 16'h0606, 0, 0, 6, "R4 ctr6");
    // R10: idle cycle drops fillValid
    @(negedge clk);
    check("R10 idle fillValid", int'(fillValid), 0);
    // R7: first demand touch keeps value; second promotes
    doReq(1, 4, 0, 0, 0, 0, "R7 first touch");
    doReq(1, 4, 0, 0, 0, 0, "R7 second touch");
    // R8: prefetch hit no effect
    doReq(1, 2, 0, 1, 0, 0, "R8 pf hit");
    // R6: demand hit promotes
    doReq(1, 1, 0, 0, 0, 0, "R6 hit");
    doReq(0, 0, 16'h0707, 1, 0, 3, "R2 fill");
    doReq(0, 0, 16'h0808, 0, 0, 7, "R2 fill last");
    // R3: set full, evictions with aging and ties
    doReq(0, 0, 16'h0909, 0, 0, 7, "R3 evict a");
    doReq(0, 0, 16'h0a0a, 0, 1, 0, "R3 evict b");
    doReq(0, 0, 16'h0b0b, 0, 0, 2, "R3 evict c");
    // random mix
    for (int n = 0; n < 600; n++) begin
      bit h = ($urandom % 3) != 0;
      doReq(h, int'($urandom % NW), int'($urandom % 16384), ($urandom % 4) == 0,
            ($urandom % 6) == 0, int'($urandom % 8), h ? "R6/R8 rand hit" : "R3 rand miss");
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule